// File: doc/BRIEF.md
# ADC Result Register Bank

This block keeps the latest conversion result for each of sixteen sample slots of a two-converter analog front end. The slots form two groups of eight: group A holds slots 0 to 7 and group B holds slots 8 to 15. The conversion engine posts a result through a one-cycle write strobe that carries a slot index and a 12-bit value. Software reads results through a simple read port.

Every slot carries two flags. The fresh flag says that an unread result is waiting. The lost flag says that a result was replaced before anyone read it. A bus read of a slot word returns the data with both flags, then clears both flags in that slot. Two more read addresses return the flags of all slots. One gives a packed status word and one gives summary bits. Reading either of these leaves every flag untouched.

Top module: `adc_result_bank`

## Requirements
- R1: A slot word (read address 0 to 15) carries the 12-bit result in bits 11:0, the lost flag in bit 16 and the fresh flag in bit 17. All other bits read 0.
- R2: A write strobe sets the fresh flag of the addressed slot and stores the value. The next read of that slot returns that value.
- R3: A write to a slot whose fresh flag is already set also sets that slot's lost flag. The lost flag is never set while the fresh flag is clear.
- R4: A read of a slot word returns the flags as they stood before the read. It then clears that slot's fresh and lost flags and leaves the stored value in place.
- R5: Read address 16 returns the packed status word. Bits 7:0 hold the fresh flags of group A slots 0 to 7. Bits 15:8 hold the fresh flags of group B slots 8 to 15. Bits 23:16 hold the lost flags of group A and bits 31:24 the lost flags of group B.
- R6: Read address 17 returns the summary word. Bit 0 is the OR of all sixteen fresh flags, bit 1 is the OR of all sixteen lost flags, and all other bits are 0.
- R7: A read of address 16, 17 or any unused address (18 to 31) changes no flag. An unused address reads 0.
- R8: When a write and a slot read hit the same slot in one cycle, the read returns the contents from before the write. Afterwards the slot holds the new value with its fresh flag set. Its lost flag then equals the fresh flag from before that cycle.
- R9: After reset, all flags are 0 and every address reads 0, including the data field of slots never written.
- R10: rd_ack pulses for exactly the cycle after each rd_en. rd_data shows the read result from that cycle on and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Result write strobe from the conversion engine |
| wr_slot | input | 4 | Slot index of the write (0-7 group A, 8-15 group B) |
| wr_data | input | 12 | Conversion result |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 5 | Read address: 0-15 slot words, 16 status, 17 summary |
| rd_data | output | 32 | Read data, valid from the cycle after rd_en |
| rd_ack | output | 1 | One-cycle pulse marking new rd_data |

## Verification
Random traffic mixes writes to random slots with reads of every address, including unused ones. This covers slots that are idle, fresh, or overwritten several times, so a slot word read shows whether the flags were cleared by the correct slot only. Directed sequences post two writes to one slot before reading it, which separates the lost flag from the fresh flag. They also read the status and summary words twice in a row to show that those reads do not clear flags. A same-cycle write and read on one slot is tried with the slot both fresh and idle beforehand, which shows the returned value is the old one and the lost flag follows the earlier fresh state.

// File: rtl/adc_result_bank_pkg.sv
package adc_result_bank_pkg;
  localparam int LOST_BIT  = 16;
  localparam int FRESH_BIT = 17;

  typedef enum logic [1:0] {
    RK_SLOT    = 2'd0,
    RK_STATUS  = 2'd1,
    RK_SUMMARY = 2'd2,
    RK_NONE    = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/arb_store.sv
// Result value storage: one write port, one registered read port, no reset,
// so it can map onto a block RAM.
module arb_store #(
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 12,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] mem [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot] <= wr_data;
  end

  // Read-first: a same-cycle write is not visible on this read.
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_slot];
  end
endmodule

// File: rtl/arb_flags.sv
// Per-slot fresh / lost / written flags.
module arb_flags #(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [SLOT_W-1:0]    wr_slot,
  input  logic                 rd_hit,
  input  logic [SLOT_W-1:0]    rd_slot,
  output logic [NUM_SLOTS-1:0] fresh_q,
  output logic [NUM_SLOTS-1:0] lost_q,
  output logic [NUM_SLOTS-1:0] written_q
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic w_hit, r_hit;
    assign w_hit = wr_en  && (wr_slot == SLOT_W'(i));
    assign r_hit = rd_hit && (rd_slot == SLOT_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        fresh_q[i]   <= 1'b0;
        lost_q[i]    <= 1'b0;
        written_q[i] <= 1'b0;
      end else if (w_hit) begin
        // write wins over a same-cycle read; lost follows the pre-read state
        lost_q[i]    <= fresh_q[i];
        fresh_q[i]   <= 1'b1;
        written_q[i] <= 1'b1;
      end else if (r_hit) begin
        fresh_q[i]   <= 1'b0;
        lost_q[i]    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/arb_readout.sv
// Read decode and output register stage. Flag bits are captured in the same
// edge as the storage read; the data field is merged in after that register.
module arb_readout
  import adc_result_bank_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 12,
  parameter int BUS_W     = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int ADDR_W   = SLOT_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [NUM_SLOTS-1:0] fresh_q,
  input  logic [NUM_SLOTS-1:0] lost_q,
  input  logic [NUM_SLOTS-1:0] written_q,
  input  logic [DATA_W-1:0]    store_q,
  output logic [BUS_W-1:0]     rd_data,
  output logic                 rd_ack
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR  = ADDR_W'(NUM_SLOTS);
  localparam logic [ADDR_W-1:0] SUMMARY_ADDR = ADDR_W'(NUM_SLOTS + 1);

  rd_kind_e          kind;
  logic [SLOT_W-1:0] slot;
  logic [BUS_W-1:0]  side_d, side_q;
  logic              dsel_q, ack_q;

  assign slot = rd_addr[SLOT_W-1:0];

  always_comb begin
    if (rd_addr < STATUS_ADDR)        kind = RK_SLOT;
    else if (rd_addr == STATUS_ADDR)  kind = RK_STATUS;
    else if (rd_addr == SUMMARY_ADDR) kind = RK_SUMMARY;
    else                              kind = RK_NONE;
  end

  always_comb begin
    side_d = '0;
    unique case (kind)
      RK_SLOT: begin
        side_d[FRESH_BIT] = fresh_q[slot];
        side_d[LOST_BIT]  = lost_q[slot];
      end
      RK_STATUS:  side_d = BUS_W'({lost_q, fresh_q});
      RK_SUMMARY: side_d = BUS_W'({|lost_q, |fresh_q});
      default:    side_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      side_q <= '0;
      dsel_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= rd_en;
      if (rd_en) begin
        side_q <= side_d;
        dsel_q <= (kind == RK_SLOT) && written_q[slot];
      end
    end
  end

  assign rd_ack  = ack_q;
  assign rd_data = side_q | (dsel_q ? BUS_W'(store_q) : '0);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int GROUPS      = 2,
  parameter int GROUP_SLOTS = 8,
  parameter int DATA_W      = 12,
  parameter int BUS_W       = 32,
  localparam int NUM_SLOTS  = GROUPS * GROUP_SLOTS,
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int ADDR_W     = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  output logic              rd_ack
);
  logic [NUM_SLOTS-1:0] fresh_q, lost_q, written_q;
  logic [DATA_W-1:0]    store_q;
  logic                 rd_slot_hit;

  assign rd_slot_hit = rd_en && (rd_addr < ADDR_W'(NUM_SLOTS));

  arb_store #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data),
    .rd_en(rd_en), .rd_slot(rd_addr[SLOT_W-1:0]), .rd_q(store_q)
  );

  arb_flags #(.NUM_SLOTS(NUM_SLOTS)) u_flags (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot),
    .rd_hit(rd_slot_hit), .rd_slot(rd_addr[SLOT_W-1:0]),
    .fresh_q(fresh_q), .lost_q(lost_q), .written_q(written_q)
  );

  arb_readout #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_readout (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .fresh_q(fresh_q), .lost_q(lost_q), .written_q(written_q),
    .store_q(store_q), .rd_data(rd_data), .rd_ack(rd_ack)
  );
endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk #(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int ADDR_W   = SLOT_W + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [SLOT_W-1:0]    wr_slot,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    rd_addr,
  input logic                 rd_ack,
  input logic [NUM_SLOTS-1:0] fresh_q,
  input logic [NUM_SLOTS-1:0] lost_q
);
  logic [SLOT_W-1:0] rs;
  logic              is_slot, same;
  assign rs      = rd_addr[SLOT_W-1:0];
  assign is_slot = rd_addr < ADDR_W'(NUM_SLOTS);
  assign same    = wr_en && rd_en && is_slot && (wr_slot == rs);

  assert_write_sets_fresh_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> fresh_q[$past(wr_slot)]);

  assert_lost_on_unread_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fresh_q[wr_slot]) |=> lost_q[$past(wr_slot)]);

  assert_lost_needs_fresh_R3: assert property (@(posedge clk) disable iff (rst)
    (lost_q & ~fresh_q) == '0);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && is_slot && !(wr_en && wr_slot == rs))
      |=> (!fresh_q[$past(rs)] && !lost_q[$past(rs)]));

  assert_other_read_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !is_slot && !wr_en) |=> ($stable(fresh_q) && $stable(lost_q)));

  assert_same_slot_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    same |=> fresh_q[$past(wr_slot)]);

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (fresh_q == '0 && lost_q == '0 && !rd_ack));

  assert_ack_follows_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_ack);

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_ack);
endmodule

bind adc_result_bank adc_result_bank_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_ack(rd_ack),
  .fresh_q(fresh_q), .lost_q(lost_q)
);

// File: tb/sim_adc_result_bank.sv
`timescale 1ns/1ps
module sim_adc_result_bank;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [3:0]  wr_slot;
  logic [11:0] wr_data;
  logic [4:0]  rd_addr;
  logic [31:0] rd_data;
  logic        rd_ack;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [11:0] m_data [16];
  logic [15:0] m_fresh, m_lost, m_written;

  always #10 clk = ~clk;

  adc_result_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ack(rd_ack)
  );

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] v = '0;
    if (a < 16) begin
      if (m_written[a]) v[11:0] = m_data[a];
      v[16] = m_lost[a];
      v[17] = m_fresh[a];
    end else if (a == 16) v = {m_lost, m_fresh};
    else if (a == 17) v = {30'd0, |m_lost, |m_fresh};
    return v;
  endfunction

  task automatic model_update(input bit w, input int s, input int d,
                              input bit r, input int a);
    if (r && a < 16 && !(w && s == a)) begin
      m_fresh[a] = 1'b0;
      m_lost[a]  = 1'b0;
    end
    if (w) begin
      m_lost[s]    = m_fresh[s];
      m_fresh[s]   = 1'b1;
      m_written[s] = 1'b1;
      m_data[s]    = d[11:0];
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_for(input int a);
    if (a < 16)  return "R1/R4 slot word";
    if (a == 16) return "R5 status word";
    if (a == 17) return "R6 summary word";
    return "R7 unused address";
  endfunction

  task automatic step(input bit w, input int s, input int d,
                      input bit r, input int a, input string tag);
    logic [31:0] exp;
    exp = model_read(a);
    wr_en = w; wr_slot = s[3:0]; wr_data = d[11:0];
    rd_en = r; rd_addr = a[4:0];
    @(posedge clk);
    model_update(w, s, d, r, a);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(rd_ack == r, "R10 ack", {31'd0, rd_ack}, {31'd0, r});
    if (r) check(rd_data == exp, tag, rd_data, exp);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R10 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_fresh = '0; m_lost = '0; m_written = '0;
    for (int i = 0; i < 16; i++) m_data[i] = '0;
    rst = 1'b1; wr_en = 0; rd_en = 0; wr_slot = 0; wr_data = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(rd_ack == 1'b0, "R9 reset ack", {31'd0, rd_ack}, 32'd0);
    check(rd_data == 32'd0, "R9 reset data", rd_data, 32'd0);
    for (int a = 0; a < 18; a++) step(0, 0, 0, 1, a, "R9 reset read");

    // R1 R2: write then read; R4 second read shows cleared flags, kept data
    step(1, 3, 12'hABC, 0, 0, "R2");
    step(0, 0, 0, 1, 3, "R1 R2 fresh word");
    step(0, 0, 0, 1, 3, "R4 cleared flags");
    // R3: two writes before a read, group B slot
    step(1, 10, 12'h111, 0, 0, "R3");
    step(1, 10, 12'h222, 0, 0, "R3");
    step(0, 0, 0, 1, 16, "R5 status with lost flag");
    step(0, 0, 0, 1, 16, "R7 status read kept flags");
    step(0, 0, 0, 1, 17, "R6 summary");
    step(0, 0, 0, 1, 17, "R7 summary read kept flags");
    step(0, 0, 0, 1, 25, "R7 unused address");
    step(0, 0, 0, 1, 10, "R3 lost word");
    step(0, 0, 0, 1, 17, "R6 summary after clear");
    // R8: same-cycle write and read, slot fresh beforehand then idle
    step(1, 5, 12'h555, 0, 0, "R8");
    step(1, 5, 12'h666, 1, 5, "R8 read returns old");
    step(0, 0, 0, 1, 5, "R8 new data lost set");
    step(1, 5, 12'h777, 1, 5, "R8 idle slot old");
    step(0, 0, 0, 1, 5, "R8 new data lost clear");

    for (int n = 0; n < 600; n++) begin
      int s, d, a;
      bit w, r;
      w = ($urandom % 3) != 0;
      r = ($urandom % 2) != 0;
      s = $urandom % 16;
      d = $urandom % 4096;
      a = ($urandom % 4 == 0) ? 16 + ($urandom % 4) : $urandom % 16;
      step(w, s, d, r, a, tag_for(a));
    end
    for (int a = 0; a < 18; a++) step(0, 0, 0, 1, a, tag_for(a));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule